// File: doc/BRIEF.md
# Auto-Incrementing Indirect Glyph Store

This block holds the user-definable character shapes of a dot-matrix display controller: 24 characters of five 7-bit column entries each, 120 entries in all. A host reaches the whole store through one 8-bit register. Writing a byte whose top bit is set moves an internal pointer. Writing a byte whose top bit is clear stores its low seven bits at the pointer. Reading that register returns the entry under the pointer.

Seen from the host, the pointer spans 0x80 to 0xF7. Each data access, write or read, moves it forward by one. After the last entry it goes back to 0x80. A pointer load above the window lands on 0x80. Internally, pointer value 0x80+n selects entry n.

A second port is combinational and read-only. Through it a character generator gives a character index and a column and receives that column's seven bits. The entry used is character × 5 + column.

Top module: `glyph_ram`

## Requirements
- R1: After reset the pointer is at 0x80, so the first data write after reset lands in entry 0 (character 0, column 0).
- R2: A strobe with `reg_addr` different from 0x05 changes neither the pointer nor any entry.
- R3: A write to 0x05 with bit 7 set and a value from 0x80 to 0xF7 sets the pointer to that value and leaves every entry unchanged.
- R4: A write to 0x05 with a value from 0xF8 to 0xFF sets the pointer to 0x80.
- R5: A write to 0x05 with bit 7 clear stores bits 6:0 at the entry under the pointer, and the pointer advances by one.
- R6: `reg_rdata` always shows {0, entry under the pointer}, so bit 7 is always 0. A read strobe to 0x05 advances the pointer by one.
- R7: A data access made while the pointer is at 0xF7 leaves the pointer at 0x80.
- R8: `lk_data` equals entry (`lk_char` × 5 + `lk_col`) when `lk_char` < 24 and `lk_col` < 5. Bit 0 of an entry is bit 0 of the written byte.
- R9: `lk_data` is 0 when `lk_char` ≥ 24 or `lk_col` ≥ 5.
- R10: When `reg_wr` and `reg_rd` are both high for address 0x05, only the write is carried out, and the pointer advances at most once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the pointer |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 8 | Host register address |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Entry under the pointer, bit 7 zero |
| lk_char | input | 5 | Lookup character index |
| lk_col | input | 3 | Lookup column index |
| lk_data | output | 7 | Lookup column bits |

## Verification
The hardest case to reach is the wrap from 0xF7 back to 0x80. The host cannot see the pointer directly, so its position is only known from which entry it reads or writes. The stimulus first fills all 120 entries with distinct values, which carries the pointer through a full wrap. It then loads 0xF7 and makes two reads in a row, so the second read shows entry 0. Loads of 0xF8 and 0xFF come next, and then a long random mix of loads, data writes, reads, simultaneous write-and-read strobes and other-address strobes. On every clock this mix is compared against a behavioural model.

// File: rtl/glyph_ram.sv
module glyph_ram #(
  parameter int        CHARS    = 24,
  parameter int        COLS     = 5,
  parameter int        CHAR_W   = 5,
  parameter int        COL_W    = 3,
  parameter logic [7:0] REG_ADDR = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [CHAR_W-1:0] lk_char,
  input  logic [COL_W-1:0]  lk_col,
  output logic [6:0]        lk_data
);
  localparam int DEPTH = CHARS * COLS;
  localparam int IW    = $clog2(DEPTH);
  localparam int LW    = CHAR_W + COL_W + 1;

  logic [6:0]    store [DEPTH];
  logic [IW-1:0] ptr;

  wire sel     = (reg_addr == REG_ADDR);
  wire do_wr   = sel & reg_wr;
  wire do_rd   = sel & reg_rd & ~reg_wr;
  wire load    = do_wr & reg_wdata[7];
  wire data_wr = do_wr & ~reg_wdata[7];
  wire advance = data_wr | do_rd;

  wire [IW-1:0] ptr_inc  = (ptr == IW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  wire [IW-1:0] load_idx = (reg_wdata[6:0] >= 7'(DEPTH)) ? '0 : reg_wdata[IW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ptr <= '0;
    else if (load)    ptr <= load_idx;
    else if (advance) ptr <= ptr_inc;

  always_ff @(posedge clk)
    if (data_wr) store[ptr] <= reg_wdata[6:0];

  assign reg_rdata = {1'b0, store[ptr]};

  wire          lk_hit  = (lk_char < CHAR_W'(CHARS)) && (lk_col < COL_W'(COLS));
  wire [LW-1:0] lk_full = LW'(lk_char) * LW'(COLS) + LW'(lk_col);
  wire [IW-1:0] lk_idx  = lk_hit ? lk_full[IW-1:0] : '0;

  assign lk_data = lk_hit ? store[lk_idx] : 7'd0;
endmodule

module glyph_ram_chk #(
  parameter int         DEPTH    = 120,
  parameter int         IW       = 7,
  parameter logic [7:0] REG_ADDR = 8'h05
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [7:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          lk_oor,
  input logic [6:0]    lk_data,
  input logic [IW-1:0] ptr
);
  wire hit    = reg_addr == REG_ADDR;
  wire acc_wr = hit && reg_wr && !reg_wdata[7];
  wire acc_rd = hit && reg_rd && !reg_wr;
  wire acc    = acc_wr || acc_rd;
  wire ld     = hit && reg_wr && reg_wdata[7];

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ptr == IW'(DEPTH - 1) |=> ptr == '0);
  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ptr != IW'(DEPTH - 1) |=> ptr == $past(ptr) + 1'b1);
  a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    ld && reg_wdata >= 8'hF8 |=> ptr == '0);
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld && reg_wdata < 8'hF8 |=> ptr == $past(reg_wdata[IW-1:0]));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(ptr));
  a_r6_msb: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] == 1'b0);
  a_r9_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lk_oor |-> lk_data == 7'd0);
endmodule

bind glyph_ram glyph_ram_chk #(.DEPTH(DEPTH), .IW(IW), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .lk_oor(!lk_hit), .lk_data(lk_data), .ptr(ptr)
);

// File: tb/tb_glyph_ram.sv
`timescale 1ns/1ps
module tb_glyph_ram;
  logic       clk = 0, rst_n = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic [4:0] lk_char = 0;
  logic [2:0] lk_col = 0;
  logic [6:0] lk_data;

  glyph_ram dut (.*);

  always #4 clk = ~clk;

  int m_mem [120];
  bit m_val [120];
  int m_ptr;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit wr, bit rd, int addr, int data, int ch, int col);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = 8'(addr); reg_wdata = 8'(data);
    lk_char = 5'(ch); lk_col = 3'(col);
    #2;
    if (m_val[m_ptr]) chk(req, "reg_rdata", int'(reg_rdata), m_mem[m_ptr]);
    if (ch >= 24 || col >= 5) chk(req, "lk_data", int'(lk_data), 0);
    else if (m_val[ch*5+col]) chk(req, "lk_data", int'(lk_data), m_mem[ch*5+col]);
    @(posedge clk);
    if (addr == 5) begin
      if (wr) begin
        if (data >= 8'h80) m_ptr = (data >= 8'hF8) ? 0 : data - 8'h80;
        else begin
          m_mem[m_ptr] = data & 8'h7F; m_val[m_ptr] = 1;
          m_ptr = (m_ptr + 1) % 120;
        end
      end else if (rd) m_ptr = (m_ptr + 1) % 120;
    end
  endtask

  initial begin
    m_ptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: first write after reset lands in entry 0
    step("R1", 1, 0, 5, 8'h2A, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 0);
    chk("R1", "entry0", int'(lk_data), 8'h2A);
    // R3 load, R5 fill all 120 entries, R7 wrap at the end
    step("R3", 1, 0, 5, 8'h80, 0, 0);
    for (int i = 0; i < 120; i++) step("R5", 1, 0, 5, (i*37+11) & 8'h7F, i/5 % 24, i % 5);
    step("R7", 0, 1, 5, 0, 0, 0);
    for (int i = 0; i < 12; i++) step("R6", 0, 1, 5, 0, 23 - i, i % 5);
    for (int c = 0; c < 24; c++)
      for (int k = 0; k < 5; k++) step("R8", 0, 0, 0, 0, c, k);
    step("R3", 1, 0, 5, 8'h80 + 77, 0, 0);
    step("R3", 0, 1, 5, 0, 0, 0);
    step("R7", 1, 0, 5, 8'hF7, 0, 0);
    step("R7", 0, 1, 5, 0, 0, 0);
    step("R7", 0, 1, 5, 0, 0, 0);
    step("R4", 1, 0, 5, 8'h85, 0, 0);
    step("R4", 1, 0, 5, 8'hF8, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0);
    step("R4", 1, 0, 5, 8'h90, 0, 0);
    step("R4", 1, 0, 5, 8'hFF, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0);
    step("R2", 1, 0, 6, 8'h12, 0, 0);
    step("R2", 1, 0, 4, 8'h93, 0, 0);
    step("R2", 0, 1, 8'h85, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 1);
    for (int c = 24; c < 32; c++) step("R9", 0, 0, 0, 0, c, 0);
    for (int k = 5; k < 8; k++) step("R9", 0, 0, 0, 0, 3, k);
    step("R10", 1, 1, 5, 8'h33, 0, 0);
    step("R10", 1, 1, 5, 8'h82, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0);
    step("R10", 0, 1, 5, 0, 0, 2);
    for (int i = 0; i < 400; i++) begin
      int a, d;
      a = ($urandom % 4 == 0) ? 6 : 5;
      d = $urandom % 256;
      step("R6", 1'($urandom), 1'($urandom), a, d, $urandom % 32, $urandom % 8);
    end
    step("R6", 0, 0, 0, 0, 0, 0);
    chk("R6", "rdata bit7", int'(reg_rdata[7]), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule